// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a master for the two-wire serial management bus used to reach PHY registers. It derives the management clock (MDC) from the system clock and drives the bidirectional data line through a separate output value, output enable and input. A host makes a request through a one-cycle valid strobe. The request carries a direction flag, a Clause 45 select, a 5-bit PHY address, a 21-bit address field and 16 bits of write data. When the transfer ends, the block pulses `done` and presents the read data and an error flag.

A Clause 22 access is one frame. It uses bits 4:0 of the address field as the register number. A Clause 45 access is two frames. The first is an address frame: it takes the device number from address bits 20:16 and carries address bits 15:0 in its data phase. The second frame reads or writes the data. On reads, the master checks the turnaround bit driven by the PHY. If that bit is wrong, the master discards the reply, flushes the bus, and reports an error. A per-PHY mask input can waive this check for PHYs known to drive the turnaround badly.

Top module: `mdio_master`

## Requirements
- R1: Every frame starts with 32 driven ones. These are followed by the start code, `01` for Clause 22 or `00` for Clause 45, and then a 2-bit opcode.
- R2: Clause 22 frames take their opcode from `cfg_c22_rd_op` (reads) or `cfg_c22_wr_op` (writes), sampled when the request is accepted. Their default use is `10` for read and `01` for write.
- R3: After the opcode come the PHY address and then a 5-bit register field, both MSB first. The register field is `req_addr[4:0]` for Clause 22 and `req_addr[20:16]` for Clause 45.
- R4: A Clause 45 access is sent as two frames. The first is an address frame with opcode `00` whose data phase is `req_addr[15:0]`. It is followed by a frame with opcode `11` (read) or `01` (write).
- R5: Write and address frames drive turnaround `1` then `0`, then 16 data bits MSB first. The line is then released for one further clock.
- R6: On read frames, the line is released after the register field. The master samples one turnaround bit, then 16 data bits MSB first, then clocks one idle bit. It completes with `rd_data` equal to the data received and `rd_err` low.
- R7: Suppose a read's turnaround bit is 1 and bit `req_phy` of `ta_ignore_mask` is clear. The master then clocks 32 more released bits and completes with `rd_data` = 0xFFFF and `rd_err` high.
- R8: A turnaround bit of 1 has no effect when the PHY's mask bit is set: the read completes as in R6.
- R9: MDC rests low when idle, with the output enable low. Each bit has MDC low for `HALF_CYC` cycles and then high for `SAMPLE_CYC` cycles. The driven data changes only while MDC is low.
- R10: Input bits are captured from the last system-clock cycle of the MDC high phase, just before MDC falls.
- R11: `busy` is high from the cycle after a request is accepted until `done`. Requests while busy are ignored. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_c45 | input | 1 | 1 = Clause 45 two-frame access |
| req_phy | input | 5 | PHY address |
| req_addr | input | 21 | Register (C22: bits 4:0) or device 20:16 plus register 15:0 (C45) |
| req_wdata | input | 16 | Write data |
| cfg_c22_rd_op | input | 2 | Clause 22 read opcode |
| cfg_c22_wr_op | input | 2 | Clause 22 write opcode |
| ta_ignore_mask | input | 32 | Per-PHY waiver of the read turnaround check |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result |
| rd_err | output | 1 | Read turnaround failure |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench sweeps four transfer kinds: Clause 22 or 45, each as a read or a write. It varies the PHY addresses, register and device numbers, and the data patterns, including all-zero, all-one and alternating words. This separates errors in field order, bit order and the placement of the start and opcode bits. Separate runs change the Clause 22 opcode inputs, which shows whether they reach the frame. They also drive a bad turnaround with the mask bit clear, with it set, and with only another PHY's bit set, which separates flush-and-error from the waived case.

The PHY model puts the inverted bit on the line after each MDC rise and the true bit only in the final high cycle. A sample point taken too early therefore reads wrong data. A request poked mid-transfer must leave the frame and the idle bus untouched.

// File: rtl/mdio_pkg.sv
// Package: shared widths, frame codes and sequencer states for the
// management-bus master. Assumes the standard 5-bit PHY and register
// fields and 16-bit data words.
package mdio_pkg;
    localparam int PHY_AW  = 5;
    localparam int REG_AW  = 5;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = REG_AW + DATA_W;
    localparam int NPHY    = 1 << PHY_AW;
    localparam int HDR_LEN = 2 + 2 + PHY_AW + REG_AW;

    localparam logic [1:0] SOF_C22   = 2'b01;
    localparam logic [1:0] SOF_C45   = 2'b00;
    localparam logic [1:0] OP45_ADDR = 2'b00;
    localparam logic [1:0] OP45_RD   = 2'b11;
    localparam logic [1:0] OP45_WR   = 2'b01;
    localparam logic [1:0] TA_DRIVE  = 2'b10;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PRE, ST_HDR, ST_TAW, ST_WDAT,
        ST_TAR, ST_RDAT, ST_FLUSH, ST_TAIL
    } mdio_state_e;
endpackage

// File: rtl/mdio_bit_clock.sv
// Bit clock: while run is high, produces MDC as HALF_CYC low cycles
// followed by SAMPLE_CYC high cycles, and flags the last high cycle
// (bit_end) where input is captured and the next output bit is loaded.
// Assumes HALF_CYC >= 1 and SAMPLE_CYC >= 1.
module mdio_bit_clock #(
    parameter int HALF_CYC   = 25,
    parameter int SAMPLE_CYC = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic bit_end
);
    localparam int MAXC = (HALF_CYC > SAMPLE_CYC) ? HALF_CYC : SAMPLE_CYC;
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
    localparam logic [CW-1:0] LO_LAST = CW'(HALF_CYC - 1);
    localparam logic [CW-1:0] HI_LAST = CW'(SAMPLE_CYC - 1);

    logic          phase_hi;
    logic [CW-1:0] cnt;

    // Phase counter: alternate low and high phases, parked low when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_hi <= 1'b0;
            cnt      <= '0;
        end else if (!phase_hi) begin
            if (cnt == LO_LAST) begin
                phase_hi <= 1'b1;
                cnt      <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            if (cnt == HI_LAST) begin
                phase_hi <= 1'b0;
                cnt      <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign mdc     = phase_hi;
    assign bit_end = run && phase_hi && (cnt == HI_LAST);
endmodule

// File: rtl/mdio_opcode_sel.sv
// Opcode selector: picks the start code and opcode for the frame being
// built from the access kind and the latched Clause 22 opcode.
// Purely combinational.
module mdio_opcode_sel
    import mdio_pkg::*;
(
    input  logic       c45,
    input  logic       write,
    input  logic       addr_phase,
    input  logic [1:0] c22_op,
    output logic [1:0] sof,
    output logic [1:0] op
);
    // Code select: Clause 45 codes are fixed, Clause 22 uses the latched one.
    always_comb begin
        if (c45) begin
            sof = SOF_C45;
            if (addr_phase)  op = OP45_ADDR;
            else if (write)  op = OP45_WR;
            else             op = OP45_RD;
        end else begin
            sof = SOF_C22;
            op  = c22_op;
        end
    end
endmodule

// File: rtl/mdio_frame_fsm.sv
// Frame sequencer: accepts a request, then walks preamble, header,
// turnaround and data phases one bit per bit_end strobe. Output bits
// come from the MSB of a shift register; read bits are shifted in on
// bit_end. Assumes bit_end is at most one cycle wide and ta_ignore_mask
// is quasi-static.
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int PRE_LEN   = 32,
    parameter int FLUSH_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_c45,
    input  logic [PHY_AW-1:0] req_phy,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        cfg_c22_rd_op,
    input  logic [1:0]        cfg_c22_wr_op,
    input  logic [NPHY-1:0]   ta_ignore_mask,
    input  logic              bit_end,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int SH_W  = (DATA_W > HDR_LEN) ? DATA_W : HDR_LEN;
    localparam int CMAX0 = (PRE_LEN > FLUSH_LEN) ? PRE_LEN : FLUSH_LEN;
    localparam int CMAX  = (CMAX0 > SH_W) ? CMAX0 : SH_W;
    localparam int CNT_W = $clog2(CMAX);
    localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_LEN - 1);
    localparam logic [CNT_W-1:0] FLUSH_LAST = CNT_W'(FLUSH_LEN - 1);
    localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(HDR_LEN - 1);
    localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] TA_LAST    = CNT_W'(1);

    mdio_state_e       state;
    logic [CNT_W-1:0]  bcnt;
    logic [SH_W-1:0]   sh;
    logic [DATA_W-1:0] rsh;
    logic              wr_q, c45_q, addr_ph;
    logic [PHY_AW-1:0] phy_q;
    logic [REG_AW-1:0] dev_q;
    logic [DATA_W-1:0] reg_q, wdata_q;
    logic [1:0]        c22_op_q;
    logic [1:0]        sof, op;
    logic [HDR_LEN-1:0] hdr_bits;

    mdio_opcode_sel u_sel (
        .c45        (c45_q),
        .write      (wr_q),
        .addr_phase (addr_ph),
        .c22_op     (c22_op_q),
        .sof        (sof),
        .op         (op)
    );

    assign hdr_bits = {sof, op, phy_q, dev_q};
    assign busy     = (state != ST_IDLE);
    assign mdio_o   = sh[SH_W-1];
    assign mdio_oe  = (state == ST_PRE) || (state == ST_HDR) ||
                      (state == ST_TAW) || (state == ST_WDAT);

    // Sequencer: request capture, per-bit phase stepping and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bcnt     <= '0;
            sh       <= '0;
            rsh      <= '0;
            rd_data  <= '0;
            rd_err   <= 1'b0;
            done     <= 1'b0;
            wr_q     <= 1'b0;
            c45_q    <= 1'b0;
            addr_ph  <= 1'b0;
            phy_q    <= '0;
            dev_q    <= '0;
            reg_q    <= '0;
            wdata_q  <= '0;
            c22_op_q <= '0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE) begin
                if (req_valid) begin
                    wr_q     <= req_write;
                    c45_q    <= req_c45;
                    addr_ph  <= req_c45;
                    phy_q    <= req_phy;
                    dev_q    <= req_c45 ? req_addr[ADDR_W-1:DATA_W]
                                        : req_addr[REG_AW-1:0];
                    reg_q    <= req_addr[DATA_W-1:0];
                    wdata_q  <= req_wdata;
                    c22_op_q <= req_write ? cfg_c22_wr_op : cfg_c22_rd_op;
                    state    <= ST_PRE;
                    bcnt     <= '0;
                    sh       <= '1;
                end
            end else if (bit_end) begin
                case (state)
                    ST_PRE: begin
                        if (bcnt == PRE_LAST) begin
                            state <= ST_HDR;
                            bcnt  <= '0;
                            sh    <= SH_W'(hdr_bits) << (SH_W - HDR_LEN);
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    ST_HDR: begin
                        if (bcnt == HDR_LAST) begin
                            bcnt <= '0;
                            if (addr_ph || wr_q) begin
                                state <= ST_TAW;
                                sh    <= SH_W'(TA_DRIVE) << (SH_W - 2);
                            end else begin
                                state <= ST_TAR;
                            end
                        end else begin
                            bcnt <= bcnt + 1'b1;
                            sh   <= sh << 1;
                        end
                    end
                    ST_TAW: begin
                        if (bcnt == TA_LAST) begin
                            state <= ST_WDAT;
                            bcnt  <= '0;
                            sh    <= SH_W'(addr_ph ? reg_q : wdata_q) << (SH_W - DATA_W);
                        end else begin
                            bcnt <= bcnt + 1'b1;
                            sh   <= sh << 1;
                        end
                    end
                    ST_WDAT: begin
                        if (bcnt == DATA_LAST) begin
                            state <= ST_TAIL;
                            bcnt  <= '0;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                            sh   <= sh << 1;
                        end
                    end
                    ST_TAR: begin
                        bcnt <= '0;
                        if (mdio_i && !ta_ignore_mask[phy_q]) state <= ST_FLUSH;
                        else                                  state <= ST_RDAT;
                    end
                    ST_RDAT: begin
                        rsh <= {rsh[DATA_W-2:0], mdio_i};
                        if (bcnt == DATA_LAST) begin
                            state <= ST_TAIL;
                            bcnt  <= '0;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    ST_FLUSH: begin
                        if (bcnt == FLUSH_LAST) begin
                            state   <= ST_IDLE;
                            done    <= 1'b1;
                            rd_data <= '1;
                            rd_err  <= 1'b1;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    ST_TAIL: begin
                        if (addr_ph) begin
                            addr_ph <= 1'b0;
                            state   <= ST_PRE;
                            bcnt    <= '0;
                            sh      <= '1;
                        end else begin
                            state  <= ST_IDLE;
                            done   <= 1'b1;
                            rd_err <= 1'b0;
                            if (!wr_q) rd_data <= rsh;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
// Management-bus master top: joins the bit clock and the frame
// sequencer. The clock runs only while a transfer is in progress, so
// MDC rests low between requests. The external tri-state buffer is
// built from mdio_o and mdio_oe outside this block.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_CYC   = 25,
    parameter int SAMPLE_CYC = 35,
    parameter int PRE_LEN    = 32,
    parameter int FLUSH_LEN  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_c45,
    input  logic [PHY_AW-1:0] req_phy,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        cfg_c22_rd_op,
    input  logic [1:0]        cfg_c22_wr_op,
    input  logic [NPHY-1:0]   ta_ignore_mask,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic bit_end;

    mdio_bit_clock #(
        .HALF_CYC   (HALF_CYC),
        .SAMPLE_CYC (SAMPLE_CYC)
    ) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .mdc     (mdc),
        .bit_end (bit_end)
    );

    mdio_frame_fsm #(
        .PRE_LEN   (PRE_LEN),
        .FLUSH_LEN (FLUSH_LEN)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_c45        (req_c45),
        .req_phy        (req_phy),
        .req_addr       (req_addr),
        .req_wdata      (req_wdata),
        .cfg_c22_rd_op  (cfg_c22_rd_op),
        .cfg_c22_wr_op  (cfg_c22_wr_op),
        .ta_ignore_mask (ta_ignore_mask),
        .bit_end        (bit_end),
        .mdio_i         (mdio_i),
        .busy           (busy),
        .done           (done),
        .rd_data        (rd_data),
        .rd_err         (rd_err),
        .mdio_o         (mdio_o),
        .mdio_oe        (mdio_oe)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Checker: port-level timing and handshake properties of the master,
// bound to every instance. The phase widths are measured with counters.
module mdio_master_chk
    import mdio_pkg::*;
#(
    parameter int HALF_CYC   = 25,
    parameter int SAMPLE_CYC = 35
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_err,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe
);
    int hi_cnt, lo_cnt;

    // Phase meters: length of the current MDC high run and busy low run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= 0;
            lo_cnt <= 0;
        end else begin
            hi_cnt <= mdc ? hi_cnt + 1 : 0;
            lo_cnt <= (mdc || !busy) ? 0 : lo_cnt + 1;
        end
    end

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));
    assert_hold_while_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> $stable(mdio_o));
    assert_low_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> (lo_cnt == HALF_CYC));
    assert_high_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> (hi_cnt == SAMPLE_CYC));
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);
    assert_err_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_data == '1));
endmodule

bind mdio_master mdio_master_chk #(
    .HALF_CYC   (HALF_CYC),
    .SAMPLE_CYC (SAMPLE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data),
    .rd_err    (rd_err),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 2;
    localparam int SAMPLE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_c45 = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [20:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  cfg_rd = 2'b10, cfg_wr = 2'b01;
    logic [31:0] mask = '0;
    logic        busy, done, rd_err, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;
    logic [15:0] rd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_master #(.HALF_CYC(HALF), .SAMPLE_CYC(SAMPLE)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_c45(req_c45), .req_phy(req_phy), .req_addr(req_addr),
        .req_wdata(req_wdata), .cfg_c22_rd_op(cfg_rd), .cfg_c22_wr_op(cfg_wr),
        .ta_ignore_mask(mask), .busy(busy), .done(done), .rd_data(rd_data),
        .rd_err(rd_err), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i));

    int n_checks = 0, n_fail = 0;
    logic drv_bits [0:16383];
    logic resp [0:4095];
    int drv_n = 0, rel_n = 0, dly = 0, hi_len = 0, lo_len = 0, tviol = 0;
    logic mdc_q = 1'b0, mdo_q = 1'b0;
    logic exp_bits [0:255];
    int exp_n;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // PHY model and monitor: records driven bits at MDC rise, answers
    // released bits with a wrong value first and the true value only in
    // the last high cycle, and measures phase widths.
    always @(negedge clk) begin
        if (dly > 0) begin
            dly--;
            if (dly == 0) mdio_i = resp[rel_n - 1];
        end
        if (mdc && !mdc_q) begin
            if (lo_len != HALF) tviol++;
            if (mdio_oe) begin
                drv_bits[drv_n] = mdio_o;
                drv_n++;
            end else begin
                mdio_i = ~resp[rel_n];
                rel_n++;
                dly = SAMPLE - 1;
                if (dly == 0) mdio_i = resp[rel_n - 1];
            end
        end
        if (!mdc && mdc_q && hi_len != SAMPLE) tviol++;
        if (mdc && mdc_q && mdio_oe && mdio_o !== mdo_q) tviol++;
        hi_len = mdc ? hi_len + 1 : 0;
        lo_len = (mdc || !busy) ? 0 : lo_len + 1;
        mdc_q = mdc;
        mdo_q = mdio_o;
    end

    task automatic put(input logic [15:0] v, input int w);
        for (int i = w - 1; i >= 0; i--) begin
            exp_bits[exp_n] = v[i];
            exp_n++;
        end
    endtask

    task automatic txn(input bit wr, input bit c45, input logic [4:0] phy,
                       input logic [20:0] addr, input logic [15:0] wd,
                       input bit ta, input logic [15:0] rresp,
                       input bit poke, input string tag);
        int base_d, base_r, w, mism, exp_rel;
        bit exp_err;
        exp_err = !wr && ta && !mask[phy];
        exp_n = 0;
        if (c45) begin
            put(16'hFFFF, 16); put(16'hFFFF, 16);
            put(16'b00, 2); put(16'b00, 2); put({11'd0, phy}, 5);
            put({11'd0, addr[20:16]}, 5); put(16'b10, 2); put(addr[15:0], 16);
            put(16'hFFFF, 16); put(16'hFFFF, 16);
            put(16'b00, 2); put(wr ? 16'b01 : 16'b11, 2); put({11'd0, phy}, 5);
            put({11'd0, addr[20:16]}, 5);
        end else begin
            put(16'hFFFF, 16); put(16'hFFFF, 16);
            put(16'b01, 2); put({14'd0, wr ? cfg_wr : cfg_rd}, 2);
            put({11'd0, phy}, 5); put({11'd0, addr[4:0]}, 5);
        end
        if (wr) begin put(16'b10, 2); put(wd, 16); end
        exp_rel = (c45 ? 1 : 0) + (wr ? 1 : (exp_err ? 33 : 18));
        base_d = drv_n;
        base_r = rel_n;
        for (int i = 0; i < 40; i++) resp[base_r + i] = 1'b0;
        if (!wr) begin
            resp[base_r + (c45 ? 1 : 0)] = ta;
            for (int i = 0; i < 16; i++) resp[base_r + (c45 ? 1 : 0) + 1 + i] = rresp[15 - i];
        end
        @(negedge clk);
        req_write = wr; req_c45 = c45; req_phy = phy; req_addr = addr; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy === 1'b1, {tag, " R11 busy after accept"}, 32'(busy), 1);
        if (poke) begin
            repeat (30) @(negedge clk);
            req_write = ~wr; req_c45 = ~c45; req_phy = ~phy; req_addr = ~addr; req_wdata = ~wd;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        w = 0;
        while (done !== 1'b1 && w < 20000) begin
            @(negedge clk);
            w++;
        end
        check(w < 20000, {tag, " completion"}, 32'(w), 20000);
        mism = 0;
        for (int i = 0; i < exp_n; i++)
            if (drv_bits[base_d + i] !== exp_bits[i]) mism++;
        check(drv_n - base_d == exp_n, {tag, " driven bit count"}, 32'(drv_n - base_d), 32'(exp_n));
        check(mism == 0, {tag, " driven bit mismatches"}, 32'(mism), 0);
        check(rel_n - base_r == exp_rel, {tag, " released bit count"}, 32'(rel_n - base_r), 32'(exp_rel));
        check(rd_err === exp_err, {tag, " error flag"}, 32'(rd_err), 32'(exp_err));
        if (!wr)
            check(rd_data === (exp_err ? 16'hFFFF : rresp), {tag, " read data"},
                  32'(rd_data), 32'(exp_err ? 16'hFFFF : rresp));
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, {tag, " R11 done single pulse"}, 32'({done, busy}), 0);
        if (poke) begin
            base_d = drv_n;
            repeat (60) @(negedge clk);
            check(busy === 1'b0 && drv_n == base_d, {tag, " R11 poke ignored"},
                  32'(drv_n - base_d), 0);
        end
    endtask

    function automatic logic [15:0] pat(input int i);
        case (i % 4)
            0: pat = 16'hA5C3;
            1: pat = 16'h0000;
            2: pat = 16'hFFFF;
            default: pat = 16'h8001;
        endcase
    endfunction

    initial begin
        repeat (5) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R11 reset handshake", 32'({busy, done}), 0);
        check(mdc === 1'b0 && mdio_oe === 1'b0, "R9 reset bus idle", 32'({mdc, mdio_oe}), 0);
        rst_n = 1'b1;
        // R1 R3 R5: Clause 22 writes over PHYs, registers and data patterns
        for (int i = 0; i < 4; i++)
            txn(1, 0, 5'(i * 10 + 1), 21'(5'(31 - i * 7)), pat(i), 0, 0, 0, "R5 C22 write");
        // R6 R10: Clause 22 reads
        for (int i = 0; i < 4; i++)
            txn(0, 0, 5'(i * 9), 21'(5'(i * 5 + 2)), 0, 0, pat(i + 1) ^ 16'h3C00, 0, "R6 C22 read");
        // R2: opcode override
        cfg_rd = 2'b00; cfg_wr = 2'b11;
        txn(1, 0, 5'd7, 21'd9, 16'h1234, 0, 0, 0, "R2 override write");
        txn(0, 0, 5'd7, 21'd9, 0, 0, 16'h4321, 0, "R2 override read");
        cfg_rd = 2'b10; cfg_wr = 2'b01;
        // R4: Clause 45 address plus data frames
        txn(1, 1, 5'd3, 21'h1F_ABCD, 16'h5A5A, 0, 0, 0, "R4 C45 write");
        txn(0, 1, 5'd30, 21'h00_0001, 0, 0, 16'hC0DE, 0, "R4 C45 read");
        txn(0, 1, 5'd16, 21'h15_8000, 0, 0, 16'h7FFE, 0, "R4 C45 read2");
        // R7: bad turnaround, mask clear (plus another PHY's bit set)
        mask = 32'h0000_0100;
        txn(0, 0, 5'd4, 21'd1, 0, 1, 16'h1111, 0, "R7 TA fail C22");
        txn(0, 1, 5'd9, 21'h02_0044, 0, 1, 16'h0000, 0, "R7 TA fail C45");
        // R8: bad turnaround waived by mask
        txn(0, 0, 5'd8, 21'd3, 0, 1, 16'hBEEF, 0, "R8 TA waived");
        mask = 32'h8000_0000;
        txn(0, 1, 5'd31, 21'h1E_00F0, 0, 1, 16'h0F0F, 0, "R8 TA waived C45");
        mask = '0;
        // R11: request during busy ignored
        txn(1, 0, 5'd12, 21'd20, 16'h6B6B, 0, 0, 1, "R11 busy write");
        check(tviol == 0, "R9 R10 MDC phase widths and hold", 32'(tviol), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule